// File: doc/BRIEF.md
# Inter-Pipe Event Flag Synchronizer

This block coordinates the asynchronous execution pipes of a single compute core, for example a load mover, a vector unit, a store mover and a scalar unit. Each flag is named by a directed pipe pair (source pipe signals destination pipe) together with a small event number. A producer pipe raises a flag with a set request. A consumer pipe holds a wait request on the same pair and number until the block grants it. The grant consumes the flag. This gives the usual handshakes: compute starts only after the load has landed, the store starts only after compute is done, and in a loop a producer waits for the consumer's "buffer free" flag before it overwrites a buffer.

A per-channel pool hands out event numbers on request and takes them back on release. Misuse produces one-cycle error pulses: a second set on a flag that is still pending, allocation from an empty pool, release of a pending or unallocated number, and any request whose source and destination pipe are the same. A stall counter flags a wait that has gone unanswered for too long. All flags are local to one core.

Top module: `evt_sync`

## Requirements
- R1: A flag is selected by source pipe, destination pipe (they must differ) and a 3-bit event number. With 4 pipes there are 12 directed channels of 8 flags each, and every flag is independent of the other 95.
- R2: A wait on a flag that is not pending is not granted, and stalls for as long as it is held. Once the flag is pending, a held wait is accepted in that cycle. `waitGrant` is high for exactly one cycle, one cycle after acceptance, and acceptance clears the flag.
- R3: A set and a wait on the same flag that is not pending, in the same cycle, count as set-then-consume: a grant follows one cycle later and the flag stays clear.
- R4: A set on a pending flag raises `doubleSetErr` one cycle later and does not change the flag. The flag is still pending once and is cleared by one wait.
- R5: While `waitGrant` is high, `waitValid` is ignored. A set arriving in that cycle stays pending.
- R6: An allocate request returns the lowest free event number of its channel on `allocId`, with `allocValid` high one cycle later.
- R7: An allocate request on a channel with all 8 numbers in use raises `allocFullErr` one cycle later, with `allocValid` low.
- R8: A release returns an allocated, non-pending number to its pool. Releasing an unallocated number, or one whose flag is pending, raises `releaseErr` one cycle later and leaves the number allocated.
- R9: Any set, wait, allocate or release whose source and destination pipe are equal raises `badChanErr` one cycle later and has no other effect.
- R10: `waitTimeout` goes high after TIMEOUT_CYCLES consecutive cycles in which a wait is held without acceptance. It returns low one cycle after the wait is dropped or accepted.
- R11: After reset, no flag is pending, no number is allocated, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setValid | input | 1 | Set request |
| setSrc | input | 2 | Set source pipe |
| setDst | input | 2 | Set destination pipe |
| setId | input | 3 | Set event number |
| waitValid | input | 1 | Wait request, held until granted |
| waitSrc | input | 2 | Wait source pipe |
| waitDst | input | 2 | Wait destination pipe |
| waitId | input | 3 | Wait event number |
| allocReq | input | 1 | Allocate request |
| allocSrc | input | 2 | Allocate source pipe |
| allocDst | input | 2 | Allocate destination pipe |
| relReq | input | 1 | Release request |
| relSrc | input | 2 | Release source pipe |
| relDst | input | 2 | Release destination pipe |
| relId | input | 3 | Event number to release |
| waitGrant | output | 1 | Wait accepted in the previous cycle |
| allocValid | output | 1 | `allocId` is valid |
| allocId | output | 3 | Allocated event number |
| allocFullErr | output | 1 | Allocation from an empty pool |
| doubleSetErr | output | 1 | Set on a pending flag |
| releaseErr | output | 1 | Illegal release |
| badChanErr | output | 1 | Request with source equal to destination |
| waitTimeout | output | 1 | Wait stalled for TIMEOUT_CYCLES cycles |

## Verification
The bench walks all 96 flags. For each one it holds a wait before any set to show the stall, sets the flag, waits on the reversed channel and on a neighbouring number to show independence, and then waits on the true flag to see the grant and the clearing. Directed sequences then cover the pending double set, a set and wait arriving together, a set arriving in the grant cycle, and the pool being drained, refilled, and misused through bad releases. The stall counter is probed one cycle before and at its limit. This separates off-by-one grant latency, flags that alias across channels, and errors that corrupt state.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int PIPES  = 4;
  localparam int IDS    = 8;
  localparam int CHANS  = PIPES * (PIPES - 1);
  localparam int PIPE_W = $clog2(PIPES);
  localparam int ID_W   = $clog2(IDS);
  localparam int CH_W   = $clog2(CHANS);
  localparam int IDX_W  = CH_W + ID_W;
  localparam int NFLAG  = CHANS * IDS;

  typedef struct packed {
    logic             setWr;
    logic [IDX_W-1:0] setIdx;
    logic             clrWr;
    logic [IDX_W-1:0] clrIdx;
    logic             allocWr;
    logic [IDX_W-1:0] allocIdx;
    logic             freeWr;
    logic [IDX_W-1:0] freeIdx;
  } evtStrobe_t;

  // dense index of a directed pipe pair (src != dst)
  function automatic logic [CH_W-1:0] chanOf(input logic [PIPE_W-1:0] s,
                                              input logic [PIPE_W-1:0] d);
    logic [CH_W-1:0] lo;
    lo = (d > s) ? CH_W'(d) - CH_W'(1) : CH_W'(d);
    return CH_W'(CH_W'(s) * CH_W'(PIPES - 1)) + lo;
  endfunction
endpackage

// File: rtl/evt_store.sv
module evt_store
  import evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  evtStrobe_t       stb,
  output logic [NFLAG-1:0] pend,
  output logic [NFLAG-1:0] used
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
      used <= '0;
    end else begin
      if (stb.setWr)   pend[stb.setIdx]   <= 1'b1;
      if (stb.clrWr)   pend[stb.clrIdx]   <= 1'b0;
      if (stb.allocWr) used[stb.allocIdx] <= 1'b1;
      if (stb.freeWr)  used[stb.freeIdx]  <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [PIPE_W-1:0] setSrc,
  input  logic [PIPE_W-1:0] setDst,
  input  logic [ID_W-1:0]   setId,
  input  logic              waitValid,
  input  logic [PIPE_W-1:0] waitSrc,
  input  logic [PIPE_W-1:0] waitDst,
  input  logic [ID_W-1:0]   waitId,
  input  logic              allocReq,
  input  logic [PIPE_W-1:0] allocSrc,
  input  logic [PIPE_W-1:0] allocDst,
  input  logic              relReq,
  input  logic [PIPE_W-1:0] relSrc,
  input  logic [PIPE_W-1:0] relDst,
  input  logic [ID_W-1:0]   relId,
  input  logic [NFLAG-1:0]  pend,
  input  logic [NFLAG-1:0]  used,
  output evtStrobe_t        stb,
  output logic              waitGrant,
  output logic              allocValid,
  output logic [ID_W-1:0]   allocId,
  output logic              allocFullErr,
  output logic              doubleSetErr,
  output logic              releaseErr,
  output logic              badChanErr,
  output logic              waitTimeout
);
  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [IDX_W-1:0] setIdx, waitIdx, relIdx;
  logic [CH_W-1:0]  allocCh;
  logic setOk, waitLive, allocOk, relOk;
  logic sameFlag, consume, isDouble, relLegal, anyFree, badAny;
  logic [ID_W-1:0]  pick;
  logic [TO_W-1:0]  stallCnt;

  always_comb begin
    setIdx   = {chanOf(setSrc, setDst), setId};
    waitIdx  = {chanOf(waitSrc, waitDst), waitId};
    relIdx   = {chanOf(relSrc, relDst), relId};
    allocCh  = chanOf(allocSrc, allocDst);
    setOk    = setValid && (setSrc != setDst);
    waitLive = waitValid && !waitGrant && (waitSrc != waitDst);
    allocOk  = allocReq && (allocSrc != allocDst);
    relOk    = relReq && (relSrc != relDst);
    sameFlag = setOk && (setIdx == waitIdx);
    consume  = waitLive && (pend[waitIdx] || sameFlag);
    isDouble = setOk && pend[setIdx];
    relLegal = used[relIdx] && !pend[relIdx];
    badAny   = (setValid && setSrc == setDst)
             || (waitValid && !waitGrant && waitSrc == waitDst)
             || (allocReq && allocSrc == allocDst)
             || (relReq && relSrc == relDst);
  end

  // lowest free number in the requested channel
  always_comb begin
    anyFree = 1'b0;
    pick    = '0;
    for (int i = IDS - 1; i >= 0; i--) begin
      if (!used[{allocCh, ID_W'(i)}]) begin
        anyFree = 1'b1;
        pick    = ID_W'(i);
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.setWr    = setOk && !isDouble && !(consume && sameFlag);
    stb.setIdx   = setIdx;
    stb.clrWr    = consume && pend[waitIdx];
    stb.clrIdx   = waitIdx;
    stb.allocWr  = allocOk && anyFree;
    stb.allocIdx = {allocCh, pick};
    stb.freeWr   = relOk && relLegal;
    stb.freeIdx  = relIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitGrant    <= 1'b0;
      allocValid   <= 1'b0;
      allocId      <= '0;
      allocFullErr <= 1'b0;
      doubleSetErr <= 1'b0;
      releaseErr   <= 1'b0;
      badChanErr   <= 1'b0;
      stallCnt     <= '0;
    end else begin
      waitGrant    <= consume;
      allocValid   <= allocOk && anyFree;
      allocId      <= pick;
      allocFullErr <= allocOk && !anyFree;
      doubleSetErr <= isDouble;
      releaseErr   <= relOk && !relLegal;
      badChanErr   <= badAny;
      if (!waitValid || consume || waitGrant)
        stallCnt <= '0;
      else if (stallCnt != TO_W'(TIMEOUT_CYCLES))
        stallCnt <= stallCnt + 1'b1;
    end
  end

  assign waitTimeout = (stallCnt == TO_W'(TIMEOUT_CYCLES));
endmodule

// File: rtl/evt_sync.sv
module evt_sync
  import evt_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        setValid,
  input  logic [1:0]  setSrc,
  input  logic [1:0]  setDst,
  input  logic [2:0]  setId,
  input  logic        waitValid,
  input  logic [1:0]  waitSrc,
  input  logic [1:0]  waitDst,
  input  logic [2:0]  waitId,
  input  logic        allocReq,
  input  logic [1:0]  allocSrc,
  input  logic [1:0]  allocDst,
  input  logic        relReq,
  input  logic [1:0]  relSrc,
  input  logic [1:0]  relDst,
  input  logic [2:0]  relId,
  output logic        waitGrant,
  output logic        allocValid,
  output logic [2:0]  allocId,
  output logic        allocFullErr,
  output logic        doubleSetErr,
  output logic        releaseErr,
  output logic        badChanErr,
  output logic        waitTimeout
);
  evtStrobe_t       stb;
  logic [NFLAG-1:0] pend, used;

  evt_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .setValid(setValid), .setSrc(setSrc), .setDst(setDst), .setId(setId),
    .waitValid(waitValid), .waitSrc(waitSrc), .waitDst(waitDst), .waitId(waitId),
    .allocReq(allocReq), .allocSrc(allocSrc), .allocDst(allocDst),
    .relReq(relReq), .relSrc(relSrc), .relDst(relDst), .relId(relId),
    .pend(pend), .used(used), .stb(stb),
    .waitGrant(waitGrant), .allocValid(allocValid), .allocId(allocId),
    .allocFullErr(allocFullErr), .doubleSetErr(doubleSetErr),
    .releaseErr(releaseErr), .badChanErr(badChanErr), .waitTimeout(waitTimeout)
  );

  evt_store u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .pend(pend), .used(used)
  );
endmodule

// File: rtl/evt_sync_chk.sv
module evt_sync_chk (
  input logic clk,
  input logic rstN,
  input logic setValid,
  input logic waitValid,
  input logic allocReq,
  input logic waitGrant,
  input logic allocValid,
  input logic allocFullErr,
  input logic doubleSetErr,
  input logic waitTimeout
);
  // R2
  grant_needs_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitGrant |-> $past(waitValid));
  // R5
  no_back_to_back_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitGrant |=> !waitGrant);
  // R4
  double_set_needs_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    doubleSetErr |-> $past(setValid));
  // R6
  alloc_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |-> $past(allocReq));
  // R7
  alloc_full_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(allocValid && allocFullErr));
  // R10
  timeout_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    !waitValid |=> !waitTimeout);
endmodule

bind evt_sync evt_sync_chk u_chk (
  .clk(clk), .rstN(rstN), .setValid(setValid), .waitValid(waitValid),
  .allocReq(allocReq), .waitGrant(waitGrant), .allocValid(allocValid),
  .allocFullErr(allocFullErr), .doubleSetErr(doubleSetErr),
  .waitTimeout(waitTimeout)
);

// File: tb/sim_evt_sync.sv
module sim_evt_sync;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setValid = 0, waitValid = 0, allocReq = 0, relReq = 0;
  logic [1:0] setSrc = 0, setDst = 0, waitSrc = 0, waitDst = 0;
  logic [1:0] allocSrc = 0, allocDst = 0, relSrc = 0, relDst = 0;
  logic [2:0] setId = 0, waitId = 0, relId = 0;
  logic waitGrant, allocValid, allocFullErr, doubleSetErr, releaseErr, badChanErr, waitTimeout;
  logic [2:0] allocId;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  evt_sync #(.TIMEOUT_CYCLES(64)) u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drvSet(input bit v, input int s, input int d, input int id);
    setValid = v; setSrc = 2'(s); setDst = 2'(d); setId = 3'(id);
  endtask
  task automatic drvWait(input bit v, input int s, input int d, input int id);
    waitValid = v; waitSrc = 2'(s); waitDst = 2'(d); waitId = 3'(id);
  endtask
  task automatic drvAlloc(input bit v, input int s, input int d);
    allocReq = v; allocSrc = 2'(s); allocDst = 2'(d);
  endtask
  task automatic drvRel(input bit v, input int s, input int d, input int id);
    relReq = v; relSrc = 2'(s); relDst = 2'(d); relId = 3'(id);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R11 reset state
    check("R11 waitGrant", waitGrant, 0);
    check("R11 allocValid", allocValid, 0);
    check("R11 errors", {allocFullErr, doubleSetErr, releaseErr, badChanErr, waitTimeout}, 0);
    rstN = 1'b1;
    step();

    // R1 / R2 sweep over all 96 flags
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        if (s == d) continue;
        for (int i = 0; i < 8; i++) begin
          drvWait(1, s, d, i); step();
          check("R2 stall", waitGrant, 0);
          step();
          check("R2 stall held", waitGrant, 0);
          drvWait(0, 0, 1, 0);
          drvSet(1, s, d, i); step();
          check("R4 no double", doubleSetErr, 0);
          check("R9 no bad", badChanErr, 0);
          drvSet(0, 0, 1, 0);
          drvWait(1, d, s, i); step();
          check("R1 reversed channel", waitGrant, 0);
          drvWait(1, s, d, i ^ 1); step();
          check("R1 other number", waitGrant, 0);
          drvWait(1, s, d, i); step();
          check("R2 grant", waitGrant, 1);
          drvWait(0, 0, 1, 0); step();
          check("R2 single pulse", waitGrant, 0);
        end
      end
    end

    // R4 double set
    drvSet(1, 0, 1, 3); step();
    check("R4 first set", doubleSetErr, 0);
    step();
    check("R4 double set flagged", doubleSetErr, 1);
    drvSet(0, 0, 1, 0);
    drvWait(1, 0, 1, 3); step();
    check("R4 grant once", waitGrant, 1);
    step();
    check("R4 grant cycle", waitGrant, 0);
    step();
    check("R4 flag cleared by one wait", waitGrant, 0);
    drvWait(0, 0, 1, 0); step();

    // R3 set and wait together
    drvSet(1, 1, 2, 6); drvWait(1, 1, 2, 6); step();
    check("R3 grant", waitGrant, 1);
    check("R3 no double", doubleSetErr, 0);
    drvSet(0, 0, 1, 0); drvWait(0, 0, 1, 0); step();
    drvWait(1, 1, 2, 6); step();
    check("R3 flag stays clear", waitGrant, 0);
    drvWait(0, 0, 1, 0); step();

    // R5 set during grant cycle
    drvSet(1, 3, 0, 2); step();
    drvSet(0, 0, 1, 0);
    drvWait(1, 3, 0, 2); step();
    check("R5 grant", waitGrant, 1);
    drvSet(1, 3, 0, 2); step();
    check("R5 wait ignored in grant cycle", waitGrant, 0);
    check("R5 set not double", doubleSetErr, 0);
    drvSet(0, 0, 1, 0); drvWait(0, 0, 1, 0); step();
    drvWait(1, 3, 0, 2); step();
    check("R5 set kept pending", waitGrant, 1);
    drvWait(0, 0, 1, 0); step();

    // R6 / R7 allocation
    drvAlloc(1, 2, 3);
    for (int k = 0; k < 8; k++) begin
      step();
      check("R6 allocValid", allocValid, 1);
      check("R6 lowest free", allocId, k);
    end
    step();
    check("R7 full err", allocFullErr, 1);
    check("R7 no valid", allocValid, 0);
    drvAlloc(0, 0, 1);

    // R8 release paths
    drvRel(1, 2, 3, 5); step();
    check("R8 legal release", releaseErr, 0);
    drvRel(0, 0, 1, 0); drvAlloc(1, 2, 3); step();
    check("R8 reuse valid", allocValid, 1);
    check("R8 reuse number", allocId, 5);
    drvAlloc(0, 0, 1);
    drvRel(1, 3, 2, 0); step();
    check("R8 unallocated release", releaseErr, 1);
    drvRel(0, 0, 1, 0);
    drvSet(1, 2, 3, 4); step();
    drvSet(0, 0, 1, 0);
    drvRel(1, 2, 3, 4); step();
    check("R8 pending release", releaseErr, 1);
    drvRel(0, 0, 1, 0); drvAlloc(1, 2, 3); step();
    check("R8 not returned", allocFullErr, 1);
    drvAlloc(0, 0, 1);
    drvWait(1, 2, 3, 4); step();
    check("R8 consume", waitGrant, 1);
    drvWait(0, 0, 1, 0);
    drvRel(1, 2, 3, 4); step();
    check("R8 release after consume", releaseErr, 0);
    drvRel(0, 0, 1, 0); drvAlloc(1, 2, 3); step();
    check("R8 returned number", allocId, 4);
    check("R8 returned valid", allocValid, 1);
    drvAlloc(0, 0, 1);

    // R9 bad channel
    drvAlloc(1, 1, 1); step();
    check("R9 alloc bad", badChanErr, 1);
    check("R9 alloc ignored", allocValid, 0);
    drvAlloc(0, 0, 1);
    drvSet(1, 1, 1, 0); step();
    check("R9 set bad", badChanErr, 1);
    drvSet(0, 0, 1, 0); step();
    check("R9 clears", badChanErr, 0);

    // R10 stall timeout
    drvWait(1, 0, 3, 7);
    repeat (63) step();
    check("R10 below limit", waitTimeout, 0);
    step();
    check("R10 at limit", waitTimeout, 1);
    drvSet(1, 0, 3, 7); step();
    check("R10 grant", waitGrant, 1);
    check("R10 cleared", waitTimeout, 0);
    drvSet(0, 0, 1, 0); drvWait(0, 0, 1, 0); step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule